// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level page table from memory. A requester hands it one access at a time: the address and flags that say whether the access is a write, comes from user privilege, or is an instruction fetch. The walker reads the directory entry. It then either maps a 4 MB page straight from that entry or reads a second-level table entry and maps a 4 KB page. It returns the physical address, the rights the requester may cache for the page, and the page size. If the walk fails, it returns a page-fault code.

The walker keeps the table's bookkeeping bits current. It writes back the accessed bit and, on writes, the dirty bit, but only when a bit actually changes. It withholds write permission from a page whose final entry is still clean, so that the first store to such a page comes back through a walk. Configuration comes in as plain level inputs and must not change while a walk is in flight: paging on, supervisor write-protect, large-page enable, the directory base and a physical address mask. Memory is one word-wide port that carries one transaction at a time under a valid/ready handshake.

Top module: `lin2phys_walker`

## Requirements
- R1: With paging off, a request completes with no memory transaction. The physical address equals the linear address, read, write and execute rights are all granted, and the page is reported as 4 KB.
- R2: The directory entry is read from ((root_base with bits 11:0 cleared) + 4 × linear[31:22]) AND phys_mask.
- R3: If the directory entry has bit 7 (size) and bit 0 (present) set and pse_en is 1, a 4 MB page is mapped from that entry with no second read. The physical address is ((entry bits 31:22, zero below) AND phys_mask) OR linear[21:0], and rsp_large is 1.
- R4: Otherwise a present directory entry points to a table. The table entry is read from ((directory entry with bits 11:0 cleared) + 4 × linear[21:12]) AND phys_mask. This also holds when bit 7 is set while pse_en is 0.
- R5: An entry with bit 0 clear at either level ends the walk with a fault. The error code has bit 0 = 0, bit 1 = write flag and bit 2 = user flag, and no right is reported.
- R6: Effective user permission (bit 2) and writable permission (bit 1) are the AND of both levels; a large page uses its one entry. A user access to a non-user page faults. A user write to a non-writable page faults. A supervisor write to a non-writable page faults only when wp_en is 1. These faults report error code bit 0 = 1, bit 1 = write flag and bit 2 = user flag.
- R7: On the 4 KB path, a directory entry with bit 5 (accessed) clear is written back with bit 5 set before the table entry is read. This happens even if the table entry then faults. An entry with bit 5 already set is not written.
- R8: On a successful walk, the final entry gets bit 5 set, and on a write also bit 6 (dirty). It is written back at its own address only when this changes its value.
- R9: Write permission is reported only when the final entry, after the update of R8, has bit 6 set and either the effective writable bit is set or the access is supervisor with wp_en 0. A successful write therefore always reports write permission.
- R10: On the 4 KB path the physical address is ((table entry bits 31:12, zero below) AND phys_mask) OR linear[11:0]; rsp_large is 0.
- R11: The walker drives at most one memory transaction at a time and holds its address, direction and data stable until mem_ready. req_ready is 1 only while idle. Each request gets exactly one single-cycle rsp_valid pulse.
- R12: The execute flag changes neither the walk nor the result, and execute permission is granted on every successful walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| paging_en | input | 1 | Translation enabled |
| wp_en | input | 1 | Supervisor writes honour read-only pages |
| pse_en | input | 1 | Directory entries may map 4 MB pages |
| root_base | input | 32 | Directory base address (bits 11:0 ignored) |
| phys_mask | input | 32 | Mask applied to every table address and page frame |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is at user privilege |
| req_exec | input | 1 | Access is an instruction fetch |
| mem_valid | output | 1 | Memory transaction requested |
| mem_ready | input | 1 | Memory transaction completes this cycle |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Entry value read, valid with mem_ready |
| rsp_valid | output | 1 | Result present for one cycle |
| rsp_fault | output | 1 | Walk ended in a page fault |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| rsp_large | output | 1 | Mapping is a 4 MB page |
| rsp_err | output | 3 | Fault code: bit 0 protection, bit 1 write, bit 2 user |

## Verification
The hardest case to reach is the difference between a supervisor write and a user write to a read-only page under both settings of write protection. A related case is a clean page that must not be granted write permission until a write has dirtied it. The bench builds the table in its own memory model and keeps the entries the walker writes back. It can therefore run the same address repeatedly while toggling wp_en. It then observes which walk writes the dirty bit, which later walk writes nothing, and how rsp_wr changes between them. Directory entries with the accessed bit clear, sitting over table entries that are not present, show that the directory write-back happens ahead of the fault.

// File: rtl/walk_pkg.sv
// Shared constants and types for the two-level page table walker.
// Assumes 32-bit entries whose flag positions are fixed by the table format.
package walk_pkg;
    localparam int ENT_SHIFT = 2;      // entries are 4 bytes

    localparam int B_PRESENT = 0;
    localparam int B_RW      = 1;
    localparam int B_US      = 2;
    localparam int B_ACC     = 5;
    localparam int B_DIRTY   = 6;
    localparam int B_SIZE    = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_WR_DIR,
        ST_RD_TBL,
        ST_WR_TBL,
        ST_DONE,
        ST_FAULT
    } walk_state_e;
endpackage

// File: rtl/walk_addr_gen.sv
// Address formation for the walker: directory and table entry addresses,
// and physical addresses for large and small pages.
// Assumes entries are VA_W bits wide and frames sit at the top of the entry.
module walk_addr_gen
    import walk_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int DIR_W = 10,
    parameter int TBL_W = 10
) (
    input  logic [VA_W-1:0] lin,
    input  logic [VA_W-1:0] root,
    input  logic [VA_W-1:0] dir_ent,
    input  logic [VA_W-1:0] tbl_ent,
    input  logic [VA_W-1:0] pmask,
    output logic [VA_W-1:0] dir_addr,
    output logic [VA_W-1:0] tbl_addr,
    output logic [VA_W-1:0] big_paddr,
    output logic [VA_W-1:0] small_paddr
);
    localparam int OFS_W     = VA_W - DIR_W - TBL_W;
    localparam int BIG_OFS_W = TBL_W + OFS_W;

    localparam logic [VA_W-1:0] SMALL_FRAME = {{(VA_W-OFS_W){1'b1}}, {OFS_W{1'b0}}};
    localparam logic [VA_W-1:0] BIG_FRAME   = {{(VA_W-BIG_OFS_W){1'b1}}, {BIG_OFS_W{1'b0}}};

    logic [VA_W-1:0] dir_step;
    logic [VA_W-1:0] tbl_step;

    // Scale the index fields to byte offsets inside each table.
    always_comb begin
        dir_step = VA_W'({lin[VA_W-1 -: DIR_W], {ENT_SHIFT{1'b0}}});
        tbl_step = VA_W'({lin[BIG_OFS_W-1 -: TBL_W], {ENT_SHIFT{1'b0}}});
    end

    // Entry addresses and translated addresses.
    always_comb begin
        dir_addr    = ((root & SMALL_FRAME) + dir_step) & pmask;
        tbl_addr    = ((dir_ent & SMALL_FRAME) + tbl_step) & pmask;
        big_paddr   = (dir_ent & BIG_FRAME & pmask) | VA_W'(lin[BIG_OFS_W-1:0]);
        small_paddr = (tbl_ent & SMALL_FRAME & pmask) | VA_W'(lin[OFS_W-1:0]);
    end
endmodule

// File: rtl/walk_rights.sv
// Rights check and bookkeeping update for the final entry of a walk.
// Assumes eff_rw/eff_us already combine both levels where two levels exist.
module walk_rights
    import walk_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic            eff_rw,
    input  logic            eff_us,
    input  logic [VA_W-1:0] final_ent,
    input  logic            is_write,
    input  logic            is_user,
    input  logic            wp,
    output logic            violate,
    output logic [VA_W-1:0] upd_ent,
    output logic            upd_changed,
    output logic            grant_wr
);
    // Protection decision for the access.
    always_comb begin
        violate = (is_user && !eff_us) ||
                  (is_write && !eff_rw && (is_user || wp));
    end

    // Accessed/dirty update and the write right reported back.
    always_comb begin
        upd_ent         = final_ent;
        upd_ent[B_ACC]  = 1'b1;
        if (is_write) begin
            upd_ent[B_DIRTY] = 1'b1;
        end
        upd_changed = (upd_ent != final_ent);
        grant_wr    = upd_ent[B_DIRTY] && (eff_rw || (!is_user && !wp));
    end
endmodule

// File: rtl/lin2phys_walker.sv
// Two-level page table walker: one request at a time, one memory
// transaction at a time. Configuration inputs must stay stable while
// a walk is in flight. Results are held for one cycle on rsp_valid.
module lin2phys_walker
    import walk_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int DIR_W = 10,
    parameter int TBL_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            paging_en,
    input  logic            wp_en,
    input  logic            pse_en,
    input  logic [VA_W-1:0] root_base,
    input  logic [VA_W-1:0] phys_mask,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_addr,
    input  logic            req_write,
    input  logic            req_user,
    input  logic            req_exec,
    output logic            mem_valid,
    input  logic            mem_ready,
    output logic            mem_we,
    output logic [VA_W-1:0] mem_addr,
    output logic [VA_W-1:0] mem_wdata,
    input  logic [VA_W-1:0] mem_rdata,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [VA_W-1:0] rsp_paddr,
    output logic            rsp_rd,
    output logic            rsp_wr,
    output logic            rsp_ex,
    output logic            rsp_large,
    output logic [2:0]      rsp_err
);
    walk_state_e     state;
    logic [VA_W-1:0] lin_q;
    logic            wr_q;
    logic            usr_q;
    logic [VA_W-1:0] dir_q;
    logic [VA_W-1:0] tbl_q;
    logic            big_q;
    logic [VA_W-1:0] paddr_q;
    logic            grant_q;
    logic [2:0]      err_q;

    logic            unused_exec;
    logic            in_tbl;
    logic [VA_W-1:0] dir_src;
    logic [VA_W-1:0] dir_addr;
    logic [VA_W-1:0] tbl_addr;
    logic [VA_W-1:0] big_paddr;
    logic [VA_W-1:0] small_paddr;
    logic            eff_rw;
    logic            eff_us;
    logic            violate;
    logic [VA_W-1:0] upd_ent;
    logic            upd_changed;
    logic            grant_wr;

    // Fetches carry no separate permission in this table format.
    assign unused_exec = req_exec;

    // Select the entries the address and rights logic look at.
    always_comb begin
        in_tbl  = (state == ST_RD_TBL);
        dir_src = (state == ST_RD_DIR) ? mem_rdata : dir_q;
        eff_rw  = mem_rdata[B_RW] & (in_tbl ? dir_q[B_RW] : 1'b1);
        eff_us  = mem_rdata[B_US] & (in_tbl ? dir_q[B_US] : 1'b1);
    end

    walk_addr_gen #(
        .VA_W  (VA_W),
        .DIR_W (DIR_W),
        .TBL_W (TBL_W)
    ) addr_gen_i (
        .lin         (lin_q),
        .root        (root_base),
        .dir_ent     (dir_src),
        .tbl_ent     (mem_rdata),
        .pmask       (phys_mask),
        .dir_addr    (dir_addr),
        .tbl_addr    (tbl_addr),
        .big_paddr   (big_paddr),
        .small_paddr (small_paddr)
    );

    walk_rights #(
        .VA_W (VA_W)
    ) rights_i (
        .eff_rw      (eff_rw),
        .eff_us      (eff_us),
        .final_ent   (mem_rdata),
        .is_write    (wr_q),
        .is_user     (usr_q),
        .wp          (wp_en),
        .violate     (violate),
        .upd_ent     (upd_ent),
        .upd_changed (upd_changed),
        .grant_wr    (grant_wr)
    );

    // Memory port: one transaction per walk state, held until mem_ready.
    always_comb begin
        mem_valid = (state == ST_RD_DIR) || (state == ST_WR_DIR) ||
                    (state == ST_RD_TBL) || (state == ST_WR_TBL);
        mem_we    = (state == ST_WR_DIR) || (state == ST_WR_TBL);
        mem_addr  = ((state == ST_RD_DIR) || (state == ST_WR_DIR)) ? dir_addr : tbl_addr;
        mem_wdata = (state == ST_WR_DIR) ? dir_q : tbl_q;
    end

    // Response port driven from state and result registers.
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_DONE) || (state == ST_FAULT);
        rsp_fault = (state == ST_FAULT);
        rsp_paddr = paddr_q;
        rsp_rd    = (state == ST_DONE);
        rsp_wr    = (state == ST_DONE) && grant_q;
        rsp_ex    = (state == ST_DONE);
        rsp_large = (state == ST_DONE) && big_q;
        rsp_err   = (state == ST_FAULT) ? err_q : 3'b000;
    end

    // Walk sequencer: decides the next step from each entry read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lin_q   <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            dir_q   <= '0;
            tbl_q   <= '0;
            big_q   <= 1'b0;
            paddr_q <= '0;
            grant_q <= 1'b0;
            err_q   <= 3'b000;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lin_q <= req_addr;
                        wr_q  <= req_write;
                        usr_q <= req_user;
                        big_q <= 1'b0;
                        if (!paging_en) begin
                            paddr_q <= req_addr;
                            grant_q <= 1'b1;
                            state   <= ST_DONE;
                        end else begin
                            state <= ST_RD_DIR;
                        end
                    end
                end
                ST_RD_DIR: begin
                    if (mem_ready) begin
                        dir_q <= mem_rdata;
                        if (!mem_rdata[B_PRESENT]) begin
                            err_q <= {usr_q, wr_q, 1'b0};
                            state <= ST_FAULT;
                        end else if (mem_rdata[B_SIZE] && pse_en) begin
                            big_q <= 1'b1;
                            if (violate) begin
                                err_q <= {usr_q, wr_q, 1'b1};
                                state <= ST_FAULT;
                            end else begin
                                dir_q   <= upd_ent;
                                paddr_q <= big_paddr;
                                grant_q <= grant_wr;
                                state   <= upd_changed ? ST_WR_DIR : ST_DONE;
                            end
                        end else begin
                            big_q <= 1'b0;
                            if (!mem_rdata[B_ACC]) begin
                                dir_q[B_ACC] <= 1'b1;
                                state        <= ST_WR_DIR;
                            end else begin
                                state <= ST_RD_TBL;
                            end
                        end
                    end
                end
                ST_WR_DIR: begin
                    if (mem_ready) begin
                        state <= big_q ? ST_DONE : ST_RD_TBL;
                    end
                end
                ST_RD_TBL: begin
                    if (mem_ready) begin
                        if (!mem_rdata[B_PRESENT]) begin
                            err_q <= {usr_q, wr_q, 1'b0};
                            state <= ST_FAULT;
                        end else if (violate) begin
                            err_q <= {usr_q, wr_q, 1'b1};
                            state <= ST_FAULT;
                        end else begin
                            tbl_q   <= upd_ent;
                            paddr_q <= small_paddr;
                            grant_q <= grant_wr;
                            state   <= upd_changed ? ST_WR_TBL : ST_DONE;
                        end
                    end
                end
                ST_WR_TBL: begin
                    if (mem_ready) begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                ST_FAULT: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Memory request held steady until accepted.
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11

    // Each result lasts exactly one cycle.
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11

    // Every entry written back carries present and accessed.
    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> mem_wdata[B_ACC] && mem_wdata[B_PRESENT]); // R8

    // A write that succeeds always comes back with write permission.
    AST_WRITE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault && wr_q |-> rsp_wr); // R9

    // With paging off the address comes back untouched.
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !paging_en |-> !rsp_fault && rsp_paddr == lin_q && !rsp_large); // R1
endmodule

// File: tb/lin2phys_walker_tb_top.sv
module lin2phys_walker_tb_top;
    logic        clk;
    logic        rst_n;
    logic        paging_en, wp_en, pse_en;
    logic [31:0] root_base, phys_mask;
    logic        req_valid, req_ready, req_write, req_user, req_exec;
    logic [31:0] req_addr;
    logic        mem_valid, mem_ready, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        rsp_valid, rsp_fault, rsp_rd, rsp_wr, rsp_ex, rsp_large;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_err;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int n_rd, n_wr;
    logic [31:0] first_wa, last_wa, last_wd;
    logic [31:0] mem_m [logic [31:0]];

    logic        g_fault, g_rd, g_wr, g_ex, g_large;
    logic [31:0] g_paddr;
    logic [2:0]  g_err;

    lin2phys_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .paging_en(paging_en), .wp_en(wp_en), .pse_en(pse_en),
        .root_base(root_base), .phys_mask(phys_mask),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_user(req_user), .req_exec(req_exec),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
        .rsp_large(rsp_large), .rsp_err(rsp_err)
    );

    initial begin
        clk = 1'b0;
        forever #2 clk = ~clk;
    end

    // Memory model: answers after lat idle cycles, commits writes.
    initial begin
        int cnt;
        logic [31:0] cap_a, cap_d;
        logic cap_we;
        cnt = 0; cap_a = 0; cap_d = 0; cap_we = 0;
        mem_ready = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
                cnt = 0;
                if (cap_we) begin
                    mem_m[cap_a] = cap_d;
                    if (n_wr == 0) first_wa = cap_a;
                    last_wa = cap_a;
                    last_wd = cap_d;
                    n_wr++;
                end else begin
                    n_rd++;
                end
            end else if (mem_valid) begin
                if (cnt >= lat) begin
                    cap_a  = mem_addr;
                    cap_we = mem_we;
                    cap_d  = mem_wdata;
                    mem_rdata = mem_m.exists(mem_addr) ? mem_m[mem_addr] : 32'h0;
                    mem_ready = 1'b1;
                end else begin
                    cnt++;
                end
            end
        end
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: run did not finish act=timeout exp=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] a, input logic w, input logic u, input logic x);
        int guard;
        n_rd = 0; n_wr = 0;
        first_wa = '1; last_wa = '1; last_wd = '0;
        @(negedge clk);
        req_addr = a; req_write = w; req_user = u; req_exec = x;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        checks++;
        if (!rsp_valid) begin
            errors++;
            $display("FAIL R11 no response act=0 exp=1");
        end
        g_fault = rsp_fault; g_paddr = rsp_paddr; g_rd = rsp_rd;
        g_wr = rsp_wr; g_ex = rsp_ex; g_large = rsp_large; g_err = rsp_err;
        @(negedge clk);
        check("R11 pulse ends", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_reset;
        check("R11 reset req_ready", 32'(req_ready), 32'd1);
        check("R11 reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R11 reset mem_valid", 32'(mem_valid), 32'd0);
    endtask

    task automatic t_paging_off;
        paging_en = 1'b0;
        walk(32'h1234_5678, 1'b1, 1'b1, 1'b0);
        check("R1 paddr", g_paddr, 32'h1234_5678);
        check("R1 rights", {29'd0, g_rd, g_wr, g_ex}, 32'd7);
        check("R1 size", 32'(g_large), 32'd0);
        check("R1 no memory", 32'(n_rd + n_wr), 32'd0);
        paging_en = 1'b1;
    endtask

    task automatic t_small_read;
        mem_m[32'h0001_0004] = 32'h0002_0027;
        mem_m[32'h0002_000C] = 32'h0ABC_D027;
        walk(32'h0040_3ABC, 1'b0, 1'b1, 1'b0);
        check("R2 R4 two reads", 32'(n_rd), 32'd2);
        check("R10 paddr", g_paddr, 32'h0ABC_DABC);
        check("R8 no write when unchanged", 32'(n_wr), 32'd0);
        check("R9 clean page no write right", {29'd0, g_rd, g_wr, g_ex}, 32'b101);
        check("R10 small size", 32'(g_large), 32'd0);
        // R12: same walk as a fetch gives the same result
        walk(32'h0040_3ABC, 1'b0, 1'b1, 1'b1);
        check("R12 fetch paddr", g_paddr, 32'h0ABC_DABC);
        check("R12 fetch rights", {28'd0, g_fault, g_rd, g_wr, g_ex}, 32'b0101);
    endtask

    task automatic t_small_accessed;
        mem_m[32'h0002_000C] = 32'h0ABC_D007;
        walk(32'h0040_3ABC, 1'b0, 1'b0, 1'b0);
        check("R8 accessed write count", 32'(n_wr), 32'd1);
        check("R8 accessed write addr", last_wa, 32'h0002_000C);
        check("R8 accessed write data", last_wd, 32'h0ABC_D027);
    endtask

    task automatic t_small_write;
        lat = 2;
        walk(32'h0040_3ABC, 1'b1, 1'b1, 1'b0);
        check("R8 dirty write data", last_wd, 32'h0ABC_D067);
        check("R8 dirty write addr", last_wa, 32'h0002_000C);
        check("R9 write right after dirty", 32'(g_wr), 32'd1);
        walk(32'h0040_3ABC, 1'b1, 1'b1, 1'b0);
        check("R8 second write no update", 32'(n_wr), 32'd0);
        check("R9 dirty page write right", 32'(g_wr), 32'd1);
        lat = 0;
    endtask

    task automatic t_dir_accessed;
        mem_m[32'h0001_0004] = 32'h0002_0007;
        walk(32'h0040_3ABC, 1'b0, 1'b1, 1'b0);
        check("R7 dir update count", 32'(n_wr), 32'd1);
        check("R7 dir update addr", first_wa, 32'h0001_0004);
        check("R7 dir update data", last_wd, 32'h0002_0027);
        check("R9 dirty read gets write right", 32'(g_wr), 32'd1);
        walk(32'h0040_3ABC, 1'b0, 1'b1, 1'b0);
        check("R7 no second dir update", 32'(n_wr), 32'd0);
    endtask

    task automatic t_mask;
        root_base = 32'h0011_0000;
        phys_mask = 32'hFFEF_FFFF;
        walk(32'h0040_3ABC, 1'b0, 1'b1, 1'b0);
        check("R2 masked walk ok", 32'(g_fault), 32'd0);
        check("R10 masked paddr", g_paddr, 32'h0AAC_DABC);
        root_base = 32'h0001_0000;
        phys_mask = 32'hFFFF_FFFF;
    endtask

    task automatic t_large;
        pse_en = 1'b1;
        mem_m[32'h0001_000C] = 32'h0800_00E7;
        walk(32'h00C1_2345, 1'b0, 1'b1, 1'b0);
        check("R3 one read", 32'(n_rd), 32'd1);
        check("R3 paddr", g_paddr, 32'h0801_2345);
        check("R3 large flag", 32'(g_large), 32'd1);
        mem_m[32'h0001_0028] = 32'h1000_0087;
        walk(32'h0280_0010, 1'b1, 1'b1, 1'b0);
        check("R8 large update data", last_wd, 32'h1000_00E7);
        check("R8 large update addr", last_wa, 32'h0001_0028);
        check("R3 large write paddr", g_paddr, 32'h1000_0010);
        check("R9 large write right", 32'(g_wr), 32'd1);
        mem_m[32'h0001_0024] = 32'h0C00_00A5;
        walk(32'h0240_0000, 1'b1, 1'b1, 1'b0);
        check("R6 large ro user write", {28'd0, g_fault, g_err}, 32'b1111);
        check("R6 large fault no write", 32'(n_wr), 32'd0);
        // R4: size bit with large pages disabled walks a table
        pse_en = 1'b0;
        mem_m[32'h0800_0048] = 32'h0055_5067;
        walk(32'h00C1_2345, 1'b0, 1'b1, 1'b0);
        check("R4 two reads", 32'(n_rd), 32'd2);
        check("R4 paddr", g_paddr, 32'h0055_5345);
        check("R4 small flag", 32'(g_large), 32'd0);
    endtask

    task automatic t_not_present;
        walk(32'h0140_0000, 1'b1, 1'b1, 1'b0);
        check("R5 dir absent code", {28'd0, g_fault, g_err}, 32'b1110);
        check("R5 no rights", {29'd0, g_rd, g_wr, g_ex}, 32'd0);
        mem_m[32'h0001_0018] = 32'h0003_0007;
        walk(32'h0180_0000, 1'b0, 1'b0, 1'b0);
        check("R5 table absent code", {28'd0, g_fault, g_err}, 32'b1000);
        check("R7 dir updated before fault", first_wa, 32'h0001_0018);
        check("R7 dir update data", last_wd, 32'h0003_0027);
    endtask

    task automatic t_protect;
        mem_m[32'h0001_001C] = 32'h0004_0027;
        mem_m[32'h0004_0000] = 32'h0011_1023;
        walk(32'h01C0_0000, 1'b0, 1'b1, 1'b0);
        check("R6 user to supervisor page", {28'd0, g_fault, g_err}, 32'b1101);
        check("R6 fault no write", 32'(n_wr), 32'd0);
        mem_m[32'h0001_0020] = 32'h0005_0023;
        mem_m[32'h0005_0000] = 32'h0022_2027;
        walk(32'h0200_0000, 1'b0, 1'b1, 1'b0);
        check("R6 user bit ANDed", {28'd0, g_fault, g_err}, 32'b1101);
        mem_m[32'h0004_0000] = 32'h0011_1025;
        wp_en = 1'b0;
        walk(32'h01C0_0000, 1'b1, 1'b1, 1'b0);
        check("R6 user write ro", {28'd0, g_fault, g_err}, 32'b1111);
        walk(32'h01C0_0000, 1'b1, 1'b0, 1'b0);
        check("R6 supervisor write ro wp off", 32'(g_fault), 32'd0);
        check("R8 supervisor dirty data", last_wd, 32'h0011_1065);
        check("R9 supervisor write right", 32'(g_wr), 32'd1);
        wp_en = 1'b1;
        walk(32'h01C0_0000, 1'b1, 1'b0, 1'b0);
        check("R6 supervisor write ro wp on", {28'd0, g_fault, g_err}, 32'b1011);
        walk(32'h01C0_0000, 1'b0, 1'b0, 1'b0);
        check("R9 ro dirty wp on no write right", {28'd0, g_fault, g_rd, g_wr, g_ex}, 32'b0101);
        wp_en = 1'b0;
        walk(32'h01C0_0000, 1'b0, 1'b0, 1'b1);
        check("R9 ro dirty wp off write right", {28'd0, g_fault, g_rd, g_wr, g_ex}, 32'b0111);
        walk(32'h01C0_0000, 1'b0, 1'b1, 1'b1);
        check("R12 fetch does not alter code", {29'd0, g_fault, g_rd, g_ex}, 32'b011);
    endtask

    initial begin
        rst_n = 1'b0;
        paging_en = 1'b1; wp_en = 1'b0; pse_en = 1'b0;
        root_base = 32'h0001_0000; phys_mask = 32'hFFFF_FFFF;
        req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_user = 1'b0; req_exec = 1'b0;
        n_rd = 0; n_wr = 0; first_wa = '1; last_wa = '1; last_wd = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_paging_off;
        t_small_read;
        t_small_accessed;
        t_small_write;
        t_dir_accessed;
        t_mask;
        t_large;
        t_not_present;
        t_protect;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule